// File: doc/BRIEF.md
# Subroutine Jump Return Stack Unit

This unit decides every control transfer of the instruction stream and keeps a small hardware stack of return addresses. Each cycle it receives one decoded operation: a conditional or unconditional jump, a subroutine call, a subroutine exit, a counter-driven loop-back, or a transfer between the top stack entry and a data port. It also receives the flags that conditions test. From these it produces, in the same cycle, a taken indication and the address the fetch logic must use next. That address is either a jump destination or the sequential address that the fetch logic supplied.

An address is a 13-bit word number plus a 3-bit syllable index. A word holds six syllables, and a half-word is three syllables. A jump destination arrives split into three fields: a 1-bit high part, a 4-bit middle part and an 8-bit low part. A separate field gives the syllable.

An exit can resume at the saved return address, or 1, 2 or 3 half-words past it. This lets a called routine return either to an error branch placed right after the call or to the normal continuation one word later. The unit owns the overflow flag, which a test consumes. It also raises a sticky fault flag on stack misuse.

Top module: `jump_link_unit`

## Requirements
- R1: An unconditional jump (op 1, condition code 0) is taken whatever the sense bit is. Its destination word is eh*4096 + em*256 + el, and its destination syllable is the syllable field.
- R2: Condition codes select these tests: 1 equal, 2 negative, 3 positive, 4 zero, 5 overflow, 6 return stack empty, 7 test register, 8 nest empty, 9 counter zero. Codes 10 to 15 test false. With sense 1 a jump is taken when the test is true; with sense 0 it is taken when the test is false. An untaken jump gives the sequential address.
- R3: A call (op 2) on a non-full stack pushes the sequential address, raises depth by one and jumps to the field destination.
- R4: An exit (op 3) on a non-empty stack pops the top entry and jumps to that entry plus halves×3 syllables, with six syllables per word and any carry added to the word modulo 8192.
- R5: A call on a full stack, or an exit, link read or link write on an empty stack, leaves depth unchanged, takes no jump and sets fault_o. fault_o stays set until reset.
- R6: ovf_o is set at the edge after ovf_set_i is high. A jump testing code 5 uses the current ovf_o and clears it at that edge, unless ovf_set_i is high in the same cycle.
- R7: Condition code 6 reflects the unit's own stack depth being zero.
- R8: A loop-back (op 4) with cnt_zero_i low jumps to syllable 0 of word cur_word_i−1, modulo 8192. With cnt_zero_i high it gives the sequential address.
- R9: link_o shows the top entry, with the word in bits 15:3 and the syllable in bits 2:0, or 0 when the stack is empty. A link read (op 5) pops it. A link write (op 6) replaces it with link_i and leaves depth unchanged.
- R10: After reset, depth_o, fault_o, ovf_o and link_o are 0.
- R11: The stack holds DEPTH (default 16) entries and returns them in last-in first-out order.
- R12: Operations 0, 5 and 6 never assert jump_o, and next_word_o/next_syl_o equal the sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | 0 none, 1 jump, 2 call, 3 exit, 4 loop-back, 5 link read, 6 link write |
| cond_i | input | 4 | Condition code for jumps |
| sense_i | input | 1 | 1 tests the plain condition, 0 its negation |
| halves_i | input | 2 | Half-words to skip past the return address on exit |
| tgt_eh_i | input | 1 | Destination word bit 12 |
| tgt_em_i | input | 4 | Destination word bits 11:8 |
| tgt_el_i | input | 8 | Destination word bits 7:0 |
| tgt_syl_i | input | 3 | Destination syllable |
| cur_word_i | input | 13 | Word holding the current instruction |
| seq_word_i | input | 13 | Word of the following instruction |
| seq_syl_i | input | 3 | Syllable of the following instruction |
| eq_i | input | 1 | Top two data cells equal |
| neg_i | input | 1 | Top data cell negative |
| pos_i | input | 1 | Top data cell positive |
| zero_i | input | 1 | Top data cell zero |
| ovf_set_i | input | 1 | Arithmetic overflow event |
| tr_i | input | 1 | Test register |
| nest_empty_i | input | 1 | Data stack empty |
| cnt_zero_i | input | 1 | Selected counter is zero |
| link_i | input | 16 | Data for a link write |
| jump_o | output | 1 | Transfer taken this cycle |
| next_word_o | output | 13 | Next instruction word |
| next_syl_o | output | 3 | Next instruction syllable |
| link_o | output | 16 | Top return entry |
| depth_o | output | 5 | Entries in the return stack |
| ovf_o | output | 1 | Overflow flag |
| fault_o | output | 1 | Sticky stack-misuse flag |

## Verification
The assertions check, on every cycle, that depth never exceeds its bound and moves by exactly one on a legal push or pop. They also check that misuse freezes depth and blocks the jump, that the fault flag never drops, that an overflow test clears the flag, and that a loop-back lands on syllable 0. Only the bench scenarios can show the rest. These are the exact destination arithmetic across the field sweep, the full table of conditions under both senses, last-in first-out order through a full stack with varied exit offsets and word carries, and the value seen at the link port after a write.

// File: rtl/jlu_pkg.sv
package jlu_pkg;
  localparam int WORD_W = 13;
  localparam int SYL_W  = 3;
  localparam int SYL_PER_WORD = 6;
  localparam int HALF_SYL = SYL_PER_WORD / 2;
  localparam int ADDR_W = WORD_W + SYL_W;
  localparam int COND_W = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t            word;
    logic [SYL_W-1:0] syl;
  } addr_t;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_EXIT  = 3'd3,
    OP_LOOP  = 3'd4,
    OP_LRD   = 3'd5,
    OP_LWR   = 3'd6
  } op_e;

  typedef enum logic [COND_W-1:0] {
    C_ALWAYS  = 4'd0,
    C_EQ      = 4'd1,
    C_NEG     = 4'd2,
    C_POS     = 4'd3,
    C_ZERO    = 4'd4,
    C_OVF     = 4'd5,
    C_RS_EMPTY= 4'd6,
    C_TR      = 4'd7,
    C_NEST_E  = 4'd8,
    C_CZERO   = 4'd9
  } cond_e;

  // Advance a return address by h half-words (three syllables each).
  function automatic addr_t skip_halves(addr_t a, logic [1:0] h);
    logic [4:0] tot;
    addr_t r;
    tot = 5'(a.syl) + 5'(h) * 5'(HALF_SYL);
    r = a;
    if (tot >= 5'(2*SYL_PER_WORD)) begin
      r.word = a.word + WORD_W'(2);
      r.syl  = SYL_W'(tot - 5'(2*SYL_PER_WORD));
    end else if (tot >= 5'(SYL_PER_WORD)) begin
      r.word = a.word + WORD_W'(1);
      r.syl  = SYL_W'(tot - 5'(SYL_PER_WORD));
    end else begin
      r.syl  = SYL_W'(tot);
    end
    return r;
  endfunction
endpackage

// File: rtl/jlu_cond.sv
module jlu_cond
  import jlu_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic              sense_i,
  input  logic              eq_i,
  input  logic              neg_i,
  input  logic              pos_i,
  input  logic              zero_i,
  input  logic              ovf_i,
  input  logic              rs_empty_i,
  input  logic              tr_i,
  input  logic              nest_empty_i,
  input  logic              cnt_zero_i,
  output logic              hit_o
);
  logic raw;

  always_comb begin
    case (cond_i)
      C_EQ:       raw = eq_i;
      C_NEG:      raw = neg_i;
      C_POS:      raw = pos_i;
      C_ZERO:     raw = zero_i;
      C_OVF:      raw = ovf_i;
      C_RS_EMPTY: raw = rs_empty_i;
      C_TR:       raw = tr_i;
      C_NEST_E:   raw = nest_empty_i;
      C_CZERO:    raw = cnt_zero_i;
      default:    raw = 1'b0;
    endcase
    if (cond_i == C_ALWAYS) hit_o = 1'b1;
    else                    hit_o = sense_i ? raw : ~raw;
  end

  always_comb begin
    if (cond_i == C_ALWAYS)
      AST_ALWAYS_TAKEN: assert (hit_o); // R1
  end
endmodule

// File: rtl/jlu_stack.sv
module jlu_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wr_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] depth_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] top_idx, push_idx;

  assign empty_o  = (cnt == '0);
  assign full_o   = (cnt == CNT_W'(DEPTH));
  assign depth_o  = cnt;
  assign top_idx  = IDX_W'(cnt - CNT_W'(1));
  assign push_idx = IDX_W'(cnt);
  assign top_o    = empty_o ? '0 : mem[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (push_i && !full_o) cnt <= cnt + CNT_W'(1);
    else if (pop_i && !empty_o) cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o)       mem[push_idx] <= din_i;
    else if (wr_i && !empty_o)   mem[top_idx]  <= din_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH)); // R11
  AST_FULL_PUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o |=> $stable(cnt)); // R5
  AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !full_o |=> cnt == $past(cnt) + CNT_W'(1)); // R3
  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !empty_o |=> cnt == $past(cnt) - CNT_W'(1)); // R4
  AST_WR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !push_i && !pop_i |=> $stable(cnt)); // R9
endmodule

// File: rtl/jump_link_unit.sv
module jump_link_unit
  import jlu_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              sense_i,
  input  logic [1:0]        halves_i,
  input  logic              tgt_eh_i,
  input  logic [3:0]        tgt_em_i,
  input  logic [7:0]        tgt_el_i,
  input  logic [SYL_W-1:0]  tgt_syl_i,
  input  logic [WORD_W-1:0] cur_word_i,
  input  logic [WORD_W-1:0] seq_word_i,
  input  logic [SYL_W-1:0]  seq_syl_i,
  input  logic              eq_i,
  input  logic              neg_i,
  input  logic              pos_i,
  input  logic              zero_i,
  input  logic              ovf_set_i,
  input  logic              tr_i,
  input  logic              nest_empty_i,
  input  logic              cnt_zero_i,
  input  logic [ADDR_W-1:0] link_i,
  output logic              jump_o,
  output logic [WORD_W-1:0] next_word_o,
  output logic [SYL_W-1:0]  next_syl_o,
  output logic [ADDR_W-1:0] link_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              ovf_o,
  output logic              fault_o
);
  op_e   op;
  addr_t tgt, seq, top, dest, push_val;
  logic  hit, empty, full, push, pop, wr, misuse, ovf_test;

  assign op  = op_e'(op_i);
  assign tgt = '{word: {tgt_eh_i, tgt_em_i, tgt_el_i}, syl: tgt_syl_i};
  assign seq = '{word: seq_word_i, syl: seq_syl_i};

  jlu_cond u_cond (
    .cond_i      (cond_i),
    .sense_i     (sense_i),
    .eq_i        (eq_i),
    .neg_i       (neg_i),
    .pos_i       (pos_i),
    .zero_i      (zero_i),
    .ovf_i       (ovf_o),
    .rs_empty_i  (empty),
    .tr_i        (tr_i),
    .nest_empty_i(nest_empty_i),
    .cnt_zero_i  (cnt_zero_i),
    .hit_o       (hit)
  );

  jlu_stack #(.DEPTH(DEPTH), .W(ADDR_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .wr_i   (wr),
    .din_i  (push_val),
    .top_o  (top),
    .empty_o(empty),
    .full_o (full),
    .depth_o(depth_o)
  );

  assign push_val = push ? seq : addr_t'(link_i);
  assign link_o   = top;

  always_comb begin
    jump_o = 1'b0;
    dest   = tgt;
    push   = 1'b0;
    pop    = 1'b0;
    wr     = 1'b0;
    misuse = 1'b0;
    case (op)
      OP_JUMP: jump_o = hit;
      OP_CALL: begin
        if (full) misuse = 1'b1;
        else begin jump_o = 1'b1; push = 1'b1; end
      end
      OP_EXIT: begin
        dest = skip_halves(top, halves_i);
        if (empty) misuse = 1'b1;
        else begin jump_o = 1'b1; pop = 1'b1; end
      end
      OP_LOOP: begin
        dest = '{word: cur_word_i - WORD_W'(1), syl: '0};
        jump_o = ~cnt_zero_i;
      end
      OP_LRD: begin
        if (empty) misuse = 1'b1;
        else pop = 1'b1;
      end
      OP_LWR: begin
        if (empty) misuse = 1'b1;
        else wr = 1'b1;
      end
      default: ;
    endcase
  end

  assign next_word_o = jump_o ? dest.word : seq_word_i;
  assign next_syl_o  = jump_o ? dest.syl  : seq_syl_i;
  assign ovf_test    = (op == OP_JUMP) && (cond_i == C_OVF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o   <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      ovf_o   <= ovf_set_i | (ovf_o & ~ovf_test);
      fault_o <= fault_o | misuse;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o); // R5
  AST_FULL_CALL_NOJUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd2 && depth_o == CNT_W'(DEPTH) |-> !jump_o); // R5
  AST_EMPTY_EXIT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd3 && depth_o == '0 |=> fault_o); // R5
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd1 && cond_i == 4'd5 && !ovf_set_i |=> !ovf_o); // R6
  AST_LOOP_SYL0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd4 && jump_o |-> next_syl_o == '0); // R8
  AST_NONJUMP_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i == 3'd5 || op_i == 3'd6) |-> !jump_o && next_word_o == seq_word_i); // R12
endmodule

// File: tb/jump_link_unit_test.sv
`timescale 1ns/1ps
module jump_link_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  op_i;
  logic [3:0]  cond_i;
  logic        sense_i;
  logic [1:0]  halves_i;
  logic        tgt_eh_i;
  logic [3:0]  tgt_em_i;
  logic [7:0]  tgt_el_i;
  logic [2:0]  tgt_syl_i;
  logic [12:0] cur_word_i, seq_word_i;
  logic [2:0]  seq_syl_i;
  logic        eq_i, neg_i, pos_i, zero_i, ovf_set_i, tr_i, nest_empty_i, cnt_zero_i;
  logic [15:0] link_i;
  logic        jump_o;
  logic [12:0] next_word_o;
  logic [2:0]  next_syl_o;
  logic [15:0] link_o;
  logic [4:0]  depth_o;
  logic        ovf_o, fault_o;

  int checks = 0;
  int fails  = 0;
  logic [12:0] mw [16];
  logic [2:0]  ms [16];

  always #2.5 clk_i = ~clk_i;

  jump_link_unit uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    op_i = 3'd0; cond_i = 4'd0; sense_i = 1'b1; halves_i = 2'd0;
    tgt_eh_i = 1'b0; tgt_em_i = 4'd0; tgt_el_i = 8'd0; tgt_syl_i = 3'd0;
    cur_word_i = 13'd0; seq_word_i = 13'd42; seq_syl_i = 3'd1;
    eq_i = 0; neg_i = 0; pos_i = 0; zero_i = 0; ovf_set_i = 0; tr_i = 0;
    nest_empty_i = 0; cnt_zero_i = 0; link_i = 16'd0;
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic do_reset();
    idle();
    rst_ni = 1'b0;
    #12;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic set_flag(input int c, input logic v);
    eq_i = ~v; neg_i = ~v; pos_i = ~v; zero_i = ~v; tr_i = ~v;
    nest_empty_i = ~v; cnt_zero_i = ~v;
    case (c)
      1: eq_i = v;
      2: neg_i = v;
      3: pos_i = v;
      4: zero_i = v;
      7: tr_i = v;
      8: nest_empty_i = v;
      9: cnt_zero_i = v;
      default: ;
    endcase
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 depth", depth_o, 0);
    chk("R10 fault", fault_o, 0);
    chk("R10 ovf", ovf_o, 0);
    chk("R10 link", link_o, 0);

    // R1 field assembly sweep
    for (int em = 0; em < 16; em++) begin
      for (int eh = 0; eh < 2; eh++) begin
        idle();
        op_i = 3'd1; cond_i = 4'd0; sense_i = em[0];
        tgt_eh_i = eh[0]; tgt_em_i = em[3:0]; tgt_el_i = 8'(em * 17 + eh * 100);
        tgt_syl_i = 3'(em % 6);
        #1;
        chk("R1 jump", jump_o, 1);
        chk("R1 word", next_word_o, eh * 4096 + em * 256 + ((em * 17 + eh * 100) % 256));
        chk("R1 syl", next_syl_o, em % 6);
        step();
      end
    end

    // R2 condition table, both senses, external flags
    for (int c = 1; c < 16; c++) begin
      if (c == 5 || c == 6) continue;
      for (int s = 0; s < 2; s++) begin
        for (int v = 0; v < 2; v++) begin
          idle();
          op_i = 3'd1; cond_i = 4'(c); sense_i = s[0];
          tgt_el_i = 8'd200; tgt_syl_i = 3'd4;
          set_flag(c, v[0]);
          #1;
          begin
            logic raw, e;
            raw = (c <= 9) ? v[0] : 1'b0;
            e = s[0] ? raw : ~raw;
            chk("R2 jump", jump_o, e);
            chk("R2 word", next_word_o, e ? 200 : 42);
          end
          step();
        end
      end
    end

    // R6 overflow flag
    idle(); ovf_set_i = 1'b1; step(); idle();
    chk("R6 set", ovf_o, 1);
    op_i = 3'd1; cond_i = 4'd5; sense_i = 1'b1; #1;
    chk("R6 test true", jump_o, 1);
    step(); idle();
    chk("R6 cleared", ovf_o, 0);
    op_i = 3'd1; cond_i = 4'd5; sense_i = 1'b0; #1;
    chk("R6 negated clear", jump_o, 1);
    step(); idle();
    ovf_set_i = 1'b1; step(); idle();
    op_i = 3'd1; cond_i = 4'd5; sense_i = 1'b0; #1;
    chk("R6 negated set", jump_o, 0);
    step(); idle();
    chk("R6 cleared by negated test", ovf_o, 0);
    op_i = 3'd1; cond_i = 4'd5; ovf_set_i = 1'b1; step(); idle();
    chk("R6 set wins", ovf_o, 1);

    // R7 empty condition on empty stack
    op_i = 3'd1; cond_i = 4'd6; sense_i = 1'b1; #1;
    chk("R7 empty taken", jump_o, 1);
    step();

    // R3 fill the stack
    for (int i = 0; i < 16; i++) begin
      idle();
      op_i = 3'd2; tgt_el_i = 8'(i); tgt_em_i = 4'd7;
      mw[i] = (i == 3) ? 13'h1FFF : 13'(100 + i * 7);
      ms[i] = (i == 3) ? 3'd4 : 3'(i % 6);
      seq_word_i = mw[i]; seq_syl_i = ms[i];
      #1;
      chk("R3 jump", jump_o, 1);
      chk("R3 word", next_word_o, 7 * 256 + i);
      step();
      chk("R3 depth", depth_o, i + 1);
      chk("R3 top", link_o, {mw[i], ms[i]});
    end
    idle(); op_i = 3'd1; cond_i = 4'd6; sense_i = 1'b1; #1;
    chk("R7 nonempty untaken", jump_o, 0);
    sense_i = 1'b0; #1;
    chk("R7 nonempty negated", jump_o, 1);
    step();

    // R5 call on full stack
    idle(); op_i = 3'd2; tgt_el_i = 8'd9; #1;
    chk("R5 full call jump", jump_o, 0);
    chk("R5 full call seq", next_word_o, 42);
    step(); idle();
    chk("R5 fault", fault_o, 1);
    chk("R5 depth held", depth_o, 16);
    chk("R11 top kept", link_o, {mw[15], ms[15]});

    // R9 link write
    op_i = 3'd6; link_i = 16'hABCD; seq_word_i = 13'd77; #1;
    chk("R9 write nojump", jump_o, 0);
    step(); idle();
    chk("R9 written", link_o, 16'hABCD);
    chk("R9 depth", depth_o, 16);
    mw[15] = 13'(16'hABCD >> 3); ms[15] = 3'(16'hABCD & 7);

    // R4/R11 unwind with offsets
    for (int i = 15; i >= 0; i--) begin
      int h, tot, ew, es;
      idle();
      h = i % 4;
      op_i = 3'd3; halves_i = 2'(h);
      tot = ms[i] + 3 * h;
      ew = (mw[i] + tot / 6) % 8192;
      es = tot % 6;
      #1;
      chk("R4 jump", jump_o, 1);
      chk("R11 exit word", next_word_o, ew);
      chk("R4 exit syl", next_syl_o, es);
      step();
      chk("R4 depth", depth_o, i);
    end
    chk("R9 empty link", link_o, 0);

    // R5 exit on empty after fresh reset
    do_reset();
    op_i = 3'd3; #1;
    chk("R5 empty exit jump", jump_o, 0);
    step(); idle();
    chk("R5 empty exit fault", fault_o, 1);
    chk("R5 empty exit depth", depth_o, 0);
    do_reset();
    op_i = 3'd5; step(); idle();
    chk("R5 empty link read fault", fault_o, 1);

    // R9 link read pops
    do_reset();
    op_i = 3'd2; seq_word_i = 13'd300; seq_syl_i = 3'd2; step(); idle();
    chk("R9 pushed", link_o, {13'd300, 3'd2});
    op_i = 3'd5; #1;
    chk("R12 link read nojump", jump_o, 0);
    chk("R12 link read seq", next_word_o, 42);
    step(); idle();
    chk("R9 popped", depth_o, 0);
    chk("R9 no fault", fault_o, 0);

    // R8 loop-back
    op_i = 3'd4; cur_word_i = 13'd500; cnt_zero_i = 1'b0; #1;
    chk("R8 taken", jump_o, 1);
    chk("R8 word", next_word_o, 499);
    chk("R8 syl", next_syl_o, 0);
    cnt_zero_i = 1'b1; #1;
    chk("R8 zero untaken", jump_o, 0);
    chk("R8 zero seq", next_syl_o, 1);
    cnt_zero_i = 1'b0; cur_word_i = 13'd0; #1;
    chk("R8 wrap", next_word_o, 8191);
    step(); idle();

    // R12 none op
    #1;
    chk("R12 none", jump_o, 0);
    chk("R12 none seq", next_word_o, 42);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule